// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. It copies data from a source address to a destination address over a simple request/grant memory bus. Every element is moved in two bus accesses: first a read, then a write. The bus request is dropped for one cycle between the read and the write, so other masters can use the bus in that cycle.

Software programs the channel through a small word-addressed register port. The working registers are the source address, the destination address and a 26-bit byte count. A control word selects:
- the element size;
- the operand set length;
- the address stepping for each side;
- the transfer mode;
- the activation source;
- reload.

Three reload registers hold the values that are restored into the working registers when the count runs out. A command register arms the channel, issues software requests, and suspends, resumes, stops or kills the channel. A sticky done flag drives the interrupt output.

Activation can come from a software command, from an internal module request line or from an external request line. The line used is the one the control word selects. The transfer mode decides how many operand sets one activation moves.

Top module: `dmac_chan`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `bus_req` is low. The register word addresses are: 0 source, 1 destination, 2 count, 3 control, 4 reload source, 5 reload destination, 6 reload count, 7 command (reads zero), 8 status. Status bits are: bit0 done flag, bit1 armed, bit2 busy, bit3 suspended.
- R2: Control bits [1:0] set the element size: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits. `bus_size` carries this code. Bus data is right-aligned and little-endian, and only the low element bytes are written back.
- R3: Control bits [6:5] set source stepping and bits [8:7] set destination stepping: 0 is fixed, 1 is increment, 2 is decrement. After each element, each address moves by the element size in bytes.
- R4: Each element is one read access, then exactly one cycle with `bus_req` low, then one write of the read data. `bus_req`, `bus_addr` and `bus_we` hold steady until `bus_gnt` is seen.
- R5: Control bits [4:2] hold n, and an operand set is 2^n elements (1 to 128). Control bits [10:9] select the mode. In single mode (0), each activation moves exactly one set.
- R6: In continuous mode (1), the first activation starts a set. Further sets follow for as long as the selected request line stays high; with the software source they always follow. The run ends when the count reaches zero.
- R7: In non-stop mode (2), one activation moves the whole count with no further requests.
- R8: After each write, the count drops by the element size in bytes, with a floor of zero. Reaching zero sets the done flag. The flag drives `irq` and stays set until software writes 1 to status bit0. Without reload, reaching zero disarms the channel.
- R9: When control bit13 is set, reaching zero copies the three reload registers into source, destination and count. The channel stays armed and the done flag is still set.
- R10: Control bits [12:11] pick the activation source: 0 is software (command bit5), 1 is a rising edge of `int_req`, 2 is a rising edge of `ext_req`. Requests from the sources not picked are ignored. Command bit0 arms the channel, provided the count is non-zero.
- R11: Command bit1 suspends the channel once the current element is finished; no bus access happens while it is suspended. Command bit2 resumes, and the run completes with every element moved.
- R12: Command bit3 stops cleanly: the element in progress completes, then the channel disarms. The done flag is not set.
- R13: Command bit4 kills at once: `bus_req` is low from the next cycle, the pending element is not written, the count is unchanged, the channel disarms and the done flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| int_req | input | 1 | Internal module request line |
| ext_req | input | 1 | External request line |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for a write access, 0 for a read access |
| bus_addr | output | 32 | Byte address of the access |
| bus_size | output | 2 | Element size code |
| bus_wdata | output | 32 | Write data, right-aligned |
| bus_gnt | input | 1 | Access completes in the cycle this is high |
| bus_rdata | input | 32 | Read data, valid while `bus_gnt` is high on a read |
| irq | output | 1 | Done interrupt, equal to the sticky flag |

## Verification
The bench bus responder grants one cycle after it sees a request. Each element therefore takes six cycles: read, grant, gap, write, grant, and a decision cycle. The done flag shows on `irq` two clock edges after the grant edge of the final write.

A register command takes effect at the clock edge on which it is written. A kill is therefore checked at the falling edge straight after the write, where `bus_req` must already be low.

Results whose timing depends on how many elements are moved are awaited by counting completed writes, or by polling the armed and flag bits. They are sampled only after that point, at a falling edge. Ignored requests and suspension are checked by watching the write count and the count register stay unchanged over a fixed window.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {SZ8 = 2'd0, SZ16 = 2'd1, SZ32 = 2'd2, SZ_RSV = 2'd3} esize_t;
    typedef enum logic [1:0] {AM_FIXED = 2'd0, AM_INC = 2'd1, AM_DEC = 2'd2, AM_RSV = 2'd3} amode_t;
    typedef enum logic [1:0] {TM_SINGLE = 2'd0, TM_CONT = 2'd1, TM_NONSTOP = 2'd2, TM_RSV = 2'd3} tmode_t;
    typedef enum logic [1:0] {TG_SW = 2'd0, TG_INT = 2'd1, TG_EXT = 2'd2, TG_RSV = 2'd3} trig_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD, ST_GAP, ST_WR, ST_CHK, ST_PAUSE
    } xfer_st_t;

    // Control word, packed LSB last: esize [1:0], setlog [4:2], smode [6:5],
    // dmode [8:7], tmode [10:9], trig [12:11], reload [13]
    typedef struct packed {
        logic   reload;
        trig_t  trig;
        tmode_t tmode;
        amode_t dmode;
        amode_t smode;
        logic [2:0] setlog;
        esize_t esize;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam int RA_SRC  = 0;
    localparam int RA_DST  = 1;
    localparam int RA_CNT  = 2;
    localparam int RA_CTRL = 3;
    localparam int RA_RSRC = 4;
    localparam int RA_RDST = 5;
    localparam int RA_RCNT = 6;
    localparam int RA_CMD  = 7;
    localparam int RA_STAT = 8;

    // command bit positions
    localparam int CB_ARM    = 0;
    localparam int CB_SUSP   = 1;
    localparam int CB_RESUME = 2;
    localparam int CB_STOP   = 3;
    localparam int CB_KILL   = 4;
    localparam int CB_SWREQ  = 5;

    function automatic logic [2:0] elem_bytes(input esize_t e);
        case (e)
            SZ8:     elem_bytes = 3'd1;
            SZ16:    elem_bytes = 3'd2;
            default: elem_bytes = 3'd4;
        endcase
    endfunction

    function automatic logic [7:0] set_elems(input logic [2:0] lg);
        set_elems = 8'd1 << lg;
    endfunction

endpackage

// File: rtl/dmac_trig.sv
module dmac_trig
    import dmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  trig_t sel,
    input  logic  sw_req,
    input  logic  int_req,
    input  logic  ext_req,
    input  logic  live,
    input  logic  take,
    output logic  pend,
    output logic  lvl
);
    logic line, prev_q, hit;

    always_comb begin
        case (sel)
            TG_INT:  line = int_req;
            TG_EXT:  line = ext_req;
            default: line = 1'b0;
        endcase
        lvl = (sel == TG_INT || sel == TG_EXT) ? line : 1'b1;
        hit = (line & ~prev_q) | ((sel == TG_SW) & sw_req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= line;
            if (!live)
                pend <= 1'b0;
            else if (hit)
                pend <= 1'b1;
            else if (take)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 26,
    parameter int RAW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    input  logic [AW-1:0]  src_q,
    input  logic [AW-1:0]  dst_q,
    input  logic [CW-1:0]  cnt_q,
    input  logic           enabled,
    input  logic           busy,
    input  logic           suspended,
    input  logic           tc_pulse,
    output ctrl_t          ctrl,
    output logic [AW-1:0]  rld_src,
    output logic [AW-1:0]  rld_dst,
    output logic [CW-1:0]  rld_cnt,
    output logic           wr_src,
    output logic           wr_dst,
    output logic           wr_cnt,
    output logic           cmd_arm,
    output logic           cmd_susp,
    output logic           cmd_resume,
    output logic           cmd_stop,
    output logic           cmd_kill,
    output logic           cmd_swreq,
    output logic           flag,
    output logic [DW-1:0]  reg_rdata
);
    logic cmd_wr, stat_wr;

    always_comb begin
        wr_src     = reg_wr && reg_addr == RAW'(RA_SRC);
        wr_dst     = reg_wr && reg_addr == RAW'(RA_DST);
        wr_cnt     = reg_wr && reg_addr == RAW'(RA_CNT);
        cmd_wr     = reg_wr && reg_addr == RAW'(RA_CMD);
        stat_wr    = reg_wr && reg_addr == RAW'(RA_STAT);
        cmd_arm    = cmd_wr && reg_wdata[CB_ARM];
        cmd_susp   = cmd_wr && reg_wdata[CB_SUSP];
        cmd_resume = cmd_wr && reg_wdata[CB_RESUME];
        cmd_stop   = cmd_wr && reg_wdata[CB_STOP];
        cmd_kill   = cmd_wr && reg_wdata[CB_KILL];
        cmd_swreq  = cmd_wr && reg_wdata[CB_SWREQ];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            rld_src <= '0;
            rld_dst <= '0;
            rld_cnt <= '0;
            flag    <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == RAW'(RA_CTRL)) ctrl    <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (reg_wr && reg_addr == RAW'(RA_RSRC)) rld_src <= reg_wdata[AW-1:0];
            if (reg_wr && reg_addr == RAW'(RA_RDST)) rld_dst <= reg_wdata[AW-1:0];
            if (reg_wr && reg_addr == RAW'(RA_RCNT)) rld_cnt <= reg_wdata[CW-1:0];
            if (tc_pulse)
                flag <= 1'b1;
            else if (stat_wr && reg_wdata[0])
                flag <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RAW'(RA_SRC):  reg_rdata = DW'(src_q);
            RAW'(RA_DST):  reg_rdata = DW'(dst_q);
            RAW'(RA_CNT):  reg_rdata = DW'(cnt_q);
            RAW'(RA_CTRL): reg_rdata = DW'(ctrl);
            RAW'(RA_RSRC): reg_rdata = DW'(rld_src);
            RAW'(RA_RDST): reg_rdata = DW'(rld_dst);
            RAW'(RA_RCNT): reg_rdata = DW'(rld_cnt);
            RAW'(RA_STAT): reg_rdata = DW'({suspended, busy, enabled, flag});
            default:       reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmac_core.sv
module dmac_core
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 26
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctrl,
    input  logic [AW-1:0] rld_src,
    input  logic [AW-1:0] rld_dst,
    input  logic [CW-1:0] rld_cnt,
    input  logic          wr_src,
    input  logic          wr_dst,
    input  logic          wr_cnt,
    input  logic [DW-1:0] wdat,
    input  logic          cmd_arm,
    input  logic          cmd_susp,
    input  logic          cmd_resume,
    input  logic          cmd_stop,
    input  logic          cmd_kill,
    input  logic          req_pend,
    input  logic          req_lvl,
    output logic          req_take,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_gnt,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] cnt_q,
    output logic          enabled,
    output logic          busy,
    output logic          suspended,
    output logic          tc_pulse
);
    xfer_st_t      state;
    logic [7:0]    elem_left;
    logic [DW-1:0] data_q, dmask;
    logic          run_q, stop_q;
    logic [2:0]    step;
    logic [AW-1:0] src_nx, dst_nx;
    logic [CW-1:0] cnt_nx;
    logic          start_ok, stop_now;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input amode_t m,
                                          input logic [2:0] s);
        case (m)
            AM_INC:  adv = a + AW'(s);
            AM_DEC:  adv = a - AW'(s);
            default: adv = a;
        endcase
    endfunction

    always_comb begin
        step   = elem_bytes(ctrl.esize);
        src_nx = adv(src_q, ctrl.smode, step);
        dst_nx = adv(dst_q, ctrl.dmode, step);
        cnt_nx = (cnt_q > CW'(step)) ? cnt_q - CW'(step) : '0;
        case (ctrl.esize)
            SZ8:     dmask = DW'(8'hFF);
            SZ16:    dmask = DW'(16'hFFFF);
            default: dmask = '1;
        endcase
        start_ok = enabled && !suspended && (cnt_q != '0) &&
                   (req_pend || (run_q && (ctrl.tmode == TM_NONSTOP ||
                                           (ctrl.tmode == TM_CONT && req_lvl))));
        req_take = (state == ST_IDLE) && start_ok && req_pend;
        stop_now = stop_q || cmd_stop;
        tc_pulse = (state == ST_CHK) && (cnt_q == '0) && !cmd_kill;
        bus_req  = (state == ST_RD) || (state == ST_WR);
        bus_we   = (state == ST_WR);
        bus_addr = (state == ST_WR) ? dst_q : src_q;
        bus_size = ctrl.esize;
        bus_wdata = data_q;
        busy     = (state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            elem_left <= '0;
            data_q    <= '0;
            run_q     <= 1'b0;
            stop_q    <= 1'b0;
            enabled   <= 1'b0;
            suspended <= 1'b0;
            src_q     <= '0;
            dst_q     <= '0;
            cnt_q     <= '0;
        end else begin
            if (wr_src) src_q <= wdat[AW-1:0];
            if (wr_dst) dst_q <= wdat[AW-1:0];
            if (wr_cnt) cnt_q <= wdat[CW-1:0];
            if (cmd_arm && cnt_q != '0) enabled <= 1'b1;
            if (cmd_susp) suspended <= 1'b1;
            else if (cmd_resume) suspended <= 1'b0;

            case (state)
                ST_IDLE: begin
                    if (cmd_stop) begin
                        enabled <= 1'b0;
                        run_q   <= 1'b0;
                    end else if (start_ok) begin
                        elem_left <= set_elems(ctrl.setlog) - 8'd1;
                        state     <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (cmd_stop) stop_q <= 1'b1;
                    if (bus_gnt) begin
                        data_q <= bus_rdata & dmask;
                        state  <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (cmd_stop) stop_q <= 1'b1;
                    state <= ST_WR;
                end
                ST_WR: begin
                    if (cmd_stop) stop_q <= 1'b1;
                    if (bus_gnt) begin
                        src_q <= src_nx;
                        dst_q <= dst_nx;
                        cnt_q <= cnt_nx;
                        state <= ST_CHK;
                    end
                end
                ST_CHK: begin
                    state  <= ST_IDLE;
                    stop_q <= 1'b0;
                    if (cnt_q == '0) begin
                        run_q <= 1'b0;
                        if (ctrl.reload) begin
                            src_q <= rld_src;
                            dst_q <= rld_dst;
                            cnt_q <= rld_cnt;
                        end else begin
                            enabled <= 1'b0;
                        end
                    end else if (stop_now) begin
                        enabled <= 1'b0;
                        run_q   <= 1'b0;
                    end else if (elem_left != 8'd0) begin
                        elem_left <= elem_left - 8'd1;
                        state     <= (suspended || cmd_susp) ? ST_PAUSE : ST_RD;
                    end else begin
                        run_q <= 1'b1;
                    end
                end
                ST_PAUSE: begin
                    if (stop_now) begin
                        enabled <= 1'b0;
                        run_q   <= 1'b0;
                        stop_q  <= 1'b0;
                        state   <= ST_IDLE;
                    end else if (!suspended) begin
                        state <= ST_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase

            if (cmd_kill) begin
                state     <= ST_IDLE;
                enabled   <= 1'b0;
                run_q     <= 1'b0;
                stop_q    <= 1'b0;
                suspended <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 26,
    parameter int RAW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic           int_req,
    input  logic           ext_req,
    output logic           bus_req,
    output logic           bus_we,
    output logic [AW-1:0]  bus_addr,
    output logic [1:0]     bus_size,
    output logic [DW-1:0]  bus_wdata,
    input  logic           bus_gnt,
    input  logic [DW-1:0]  bus_rdata,
    output logic           irq
);
    ctrl_t         ctrl;
    logic [AW-1:0] rld_src, rld_dst, src_q, dst_q;
    logic [CW-1:0] rld_cnt, cnt_q;
    logic wr_src, wr_dst, wr_cnt;
    logic cmd_arm, cmd_susp, cmd_resume, cmd_stop, cmd_kill, cmd_swreq;
    logic enabled, busy, suspended, tc_pulse, flag;
    logic req_pend, req_lvl, req_take;

    dmac_regs #(.AW(AW), .DW(DW), .CW(CW), .RAW(RAW)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .enabled(enabled), .busy(busy),
        .suspended(suspended), .tc_pulse(tc_pulse), .ctrl(ctrl),
        .rld_src(rld_src), .rld_dst(rld_dst), .rld_cnt(rld_cnt),
        .wr_src(wr_src), .wr_dst(wr_dst), .wr_cnt(wr_cnt),
        .cmd_arm(cmd_arm), .cmd_susp(cmd_susp), .cmd_resume(cmd_resume),
        .cmd_stop(cmd_stop), .cmd_kill(cmd_kill), .cmd_swreq(cmd_swreq),
        .flag(flag), .reg_rdata(reg_rdata)
    );

    dmac_trig u_trig (
        .clk(clk), .rst(rst), .sel(ctrl.trig), .sw_req(cmd_swreq),
        .int_req(int_req), .ext_req(ext_req), .live(enabled | cmd_arm),
        .take(req_take), .pend(req_pend), .lvl(req_lvl)
    );

    dmac_core #(.AW(AW), .DW(DW), .CW(CW)) u_core (
        .clk(clk), .rst(rst), .ctrl(ctrl),
        .rld_src(rld_src), .rld_dst(rld_dst), .rld_cnt(rld_cnt),
        .wr_src(wr_src), .wr_dst(wr_dst), .wr_cnt(wr_cnt), .wdat(reg_wdata),
        .cmd_arm(cmd_arm), .cmd_susp(cmd_susp), .cmd_resume(cmd_resume),
        .cmd_stop(cmd_stop), .cmd_kill(cmd_kill),
        .req_pend(req_pend), .req_lvl(req_lvl), .req_take(req_take),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
        .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
        .enabled(enabled), .busy(busy), .suspended(suspended), .tc_pulse(tc_pulse)
    );

    assign irq = flag;
endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 26,
    parameter int RAW = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           reg_wr,
    input logic [RAW-1:0] reg_addr,
    input logic [DW-1:0]  reg_wdata,
    input logic           bus_req,
    input logic           bus_we,
    input logic           bus_gnt,
    input logic [AW-1:0]  bus_addr,
    input logic           irq,
    input logic [CW-1:0]  cnt
);
    logic kill_wr;
    assign kill_wr = reg_wr && reg_addr == RAW'(7) && reg_wdata[4];

    assert_gap_after_read_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_gnt) |=> !bus_req);

    assert_hold_until_grant_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt && !kill_wr) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    assert_irq_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(cnt) == '0));

    assert_count_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_gnt && cnt != '0 && !reg_wr) |=> (cnt < $past(cnt)));

    assert_kill_drops_bus_R13: assert property (@(posedge clk) disable iff (rst)
        kill_wr |=> !bus_req);

    assert_kill_no_irq_R13: assert property (@(posedge clk) disable iff (rst)
        (kill_wr && !irq) |=> !irq);
endmodule

bind dmac_chan dmac_chan_chk #(.AW(AW), .DW(DW), .CW(CW), .RAW(RAW)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .irq(irq), .cnt(cnt_q)
);

// File: tb/sim_dmac_chan.sv
`timescale 1ns/1ps
module sim_dmac_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        int_req = 1'b0, ext_req = 1'b0;
    logic        bus_req, bus_we, bus_gnt = 1'b0;
    logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
    logic [1:0]  bus_size;
    logic        irq;

    logic        stall = 1'b0;
    int          wcount = 0;
    int          gap_err = 0;
    logic [1:0]  last_size = '0;
    logic        rd_done = 1'b0;
    logic [7:0]  mem [256];
    logic [7:0]  ref_mem [256];
    int          checks = 0, failures = 0;

    always #5 clk = ~clk;

    dmac_chan u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .int_req(int_req), .ext_req(ext_req),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] rd_mem(input logic [31:0] a, input logic [1:0] sz);
        logic [31:0] v = '0;
        for (int i = 0; i < (1 << sz); i++) v[i*8 +: 8] = mem[8'(a + 32'(i))];
        return v;
    endfunction

    // bus responder: grant one cycle after request
    always @(posedge clk) begin
        if (rst) begin
            bus_gnt <= 1'b0;
        end else if (bus_gnt) begin
            bus_gnt <= 1'b0;
            if (bus_req && bus_we) begin
                for (int i = 0; i < (1 << bus_size); i++)
                    mem[8'(bus_addr + 32'(i))] <= bus_wdata[i*8 +: 8];
                wcount <= wcount + 1;
                last_size <= bus_size;
            end
        end else if (bus_req && !stall) begin
            bus_gnt <= 1'b1;
            if (!bus_we) bus_rdata <= rd_mem(bus_addr, bus_size);
        end
    end

    // gap monitor
    always @(posedge clk) rd_done <= bus_req && !bus_we && bus_gnt;
    always @(negedge clk) if (rd_done && bus_req) gap_err <= gap_err + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 4'(a);
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mk(input int es, input int sl, input int sm, input int dm,
                                       input int tm, input int tg, input int rl);
        return 32'(es | (sl << 2) | (sm << 5) | (dm << 7) | (tm << 9) | (tg << 11) | (rl << 13));
    endfunction

    task automatic init_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 37 + 11);
            ref_mem[i] = mem[i];
        end
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c,
                         input logic [31:0] ctl);
        wr(0, s); wr(1, d); wr(2, c); wr(3, ctl);
    endtask

    task automatic wait_disarm(input string tag);
        logic [31:0] st;
        int n = 0;
        rd(8, st);
        while (st[1] && n < 5000) begin
            @(negedge clk); rd(8, st); n++;
        end
        check({tag, " disarm in time"}, 32'(st[1]), 32'd0);
    endtask

    task automatic wait_writes(input int target, input string tag);
        int n = 0;
        while (wcount < target && n < 5000) begin
            @(negedge clk); n++;
        end
        check({tag, " writes reached"}, 32'(wcount >= target), 32'd1);
        repeat (10) @(negedge clk);
    endtask

    task automatic check_copy(input int s, input int d, input int len, input string tag);
        for (int i = 0; i < len; i++)
            check(tag, 32'(mem[8'(d + i)]), 32'(ref_mem[8'(s + i)]));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 9; a++) begin
            rd(a, v);
            check("R1 reset register", v, 32'd0);
        end
        check("R1 reset irq", 32'(irq), 32'd0);
        check("R1 reset bus_req", 32'(bus_req), 32'd0);
    endtask

    task automatic t_nonstop();
        logic [31:0] v;
        int w0;
        init_mem(); w0 = wcount;
        setup(32'h10, 32'h80, 32'd16, mk(2, 0, 1, 1, 2, 0, 0));
        wr(7, 32'h21);
        wait_disarm("R7");
        check("R7 word writes", 32'(wcount - w0), 32'd4);
        check_copy(16'h10, 16'h80, 16, "R7 copied byte");
        check("R2 size code 32-bit", 32'(last_size), 32'd2);
        rd(0, v); check("R3 src incremented", v, 32'h20);
        rd(1, v); check("R3 dst incremented", v, 32'h90);
        rd(2, v); check("R8 count zero", v, 32'd0);
        check("R8 irq set", 32'(irq), 32'd1);
        check("R4 no request in gap", 32'(gap_err), 32'd0);
        wr(8, 32'h1);
        check("R8 irq cleared by w1c", 32'(irq), 32'd0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        int w0;
        init_mem(); w0 = wcount;
        setup(32'h20, 32'hA0, 32'd8, mk(0, 2, 1, 1, 0, 0, 0));
        wr(7, 32'h21);
        wait_writes(w0 + 4, "R5 first set");
        check("R5 one set only", 32'(wcount - w0), 32'd4);
        rd(2, v); check("R5 count after set", v, 32'd4);
        rd(8, v); check("R5 still armed", 32'(v[1]), 32'd1);
        check("R5 no irq yet", 32'(irq), 32'd0);
        check_copy(16'h20, 16'hA0, 4, "R2 byte copied");
        check("R2 byte untouched", 32'(mem[8'hA4]), 32'(ref_mem[8'hA4]));
        check("R2 size code 8-bit", 32'(last_size), 32'd0);
        wr(7, 32'h20);
        wait_writes(w0 + 8, "R5 second set");
        rd(2, v); check("R5 count done", v, 32'd0);
        check("R8 irq after count", 32'(irq), 32'd1);
        rd(8, v); check("R8 disarmed", 32'(v[1]), 32'd0);
        wr(8, 32'h1);
    endtask

    task automatic t_decfixed();
        logic [31:0] v;
        int w0;
        init_mem(); w0 = wcount;
        setup(32'h40, 32'hC0, 32'd6, mk(1, 7, 2, 0, 2, 0, 0));
        wr(7, 32'h21);
        wait_disarm("R3 dec");
        check("R3 halfword writes", 32'(wcount - w0), 32'd3);
        rd(0, v); check("R3 src decremented", v, 32'h3A);
        rd(1, v); check("R3 dst fixed", v, 32'hC0);
        check("R3 last element lo", 32'(mem[8'hC0]), 32'(ref_mem[8'h3C]));
        check("R3 last element hi", 32'(mem[8'hC1]), 32'(ref_mem[8'h3D]));
        check("R2 halfword upper untouched", 32'(mem[8'hC2]), 32'(ref_mem[8'hC2]));
        wr(8, 32'h1);
    endtask

    task automatic t_cont();
        logic [31:0] v;
        int w0;
        init_mem(); w0 = wcount;
        setup(32'h50, 32'hD0, 32'd8, mk(0, 1, 1, 1, 1, 2, 0));
        wr(7, 32'h01);
        @(negedge clk); int_req = 1'b1;
        repeat (3) @(negedge clk); int_req = 1'b0;
        wr(7, 32'h20);
        repeat (20) @(negedge clk);
        check("R10 other sources ignored writes", 32'(wcount - w0), 32'd0);
        rd(2, v); check("R10 other sources ignored count", v, 32'd8);
        ext_req = 1'b1;
        wait_disarm("R6 ext held");
        ext_req = 1'b0;
        check("R6 all moved", 32'(wcount - w0), 32'd8);
        check_copy(16'h50, 16'hD0, 8, "R6 copy");
        wr(8, 32'h1);
        // internal source, one short pulse: only first set
        init_mem(); w0 = wcount;
        setup(32'h58, 32'hE0, 32'd8, mk(0, 1, 1, 1, 1, 1, 0));
        wr(7, 32'h01);
        int_req = 1'b1; @(negedge clk); int_req = 1'b0;
        wait_writes(w0 + 2, "R6 pulse set");
        repeat (20) @(negedge clk);
        rd(2, v); check("R6 stops when line low", v, 32'd6);
        int_req = 1'b1;
        wait_disarm("R10 internal held");
        int_req = 1'b0;
        check_copy(16'h58, 16'hE0, 8, "R10 internal copy");
        wr(8, 32'h1);
    endtask

    task automatic t_reload();
        logic [31:0] v;
        int n = 0;
        init_mem();
        setup(32'h60, 32'hE0, 32'd4, mk(2, 0, 1, 1, 2, 0, 1));
        wr(4, 32'h04); wr(5, 32'h84); wr(6, 32'd12);
        wr(7, 32'h21);
        while (!irq && n < 3000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
        rd(0, v); check("R9 src reloaded", v, 32'h04);
        rd(1, v); check("R9 dst reloaded", v, 32'h84);
        rd(2, v); check("R9 count reloaded", v, 32'd12);
        rd(8, v); check("R9 stays armed, flag set", v & 32'h3, 32'h3);
        check_copy(16'h60, 16'hE0, 4, "R9 first copy");
        wr(8, 32'h1);
        check("R8 flag cleared", 32'(irq), 32'd0);
        wr(7, 32'h20);
        n = 0;
        while (!irq && n < 3000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
        check_copy(16'h04, 16'h84, 12, "R9 reloaded copy");
        rd(2, v); check("R9 count reloaded again", v, 32'd12);
        wr(7, 32'h10);
        wr(8, 32'h1);
    endtask

    task automatic t_suspend();
        logic [31:0] v, c1;
        int w0, w1;
        init_mem(); w0 = wcount;
        setup(32'h00, 32'h80, 32'd32, mk(0, 7, 1, 1, 2, 0, 0));
        wr(7, 32'h21);
        wait_writes(w0 + 5, "R11 before suspend");
        wr(7, 32'h02);
        repeat (10) @(negedge clk);
        w1 = wcount; rd(2, c1);
        repeat (30) @(negedge clk);
        check("R11 no writes while suspended", 32'(wcount), 32'(w1));
        rd(2, v); check("R11 count stable", v, c1);
        check("R11 bus idle", 32'(bus_req), 32'd0);
        rd(8, v); check("R11 suspended bit", 32'(v[3]), 32'd1);
        wr(7, 32'h04);
        wait_disarm("R11 resume");
        check("R11 total writes", 32'(wcount - w0), 32'd32);
        check_copy(16'h00, 16'h80, 32, "R11 copy");
        wr(8, 32'h1);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        int w0;
        init_mem(); w0 = wcount;
        stall = 1'b1;
        setup(32'h10, 32'h90, 32'd32, mk(2, 0, 1, 1, 2, 0, 0));
        wr(7, 32'h21);
        repeat (5) @(negedge clk);
        wr(7, 32'h08);
        stall = 1'b0;
        repeat (30) @(negedge clk);
        check("R12 element finished", 32'(wcount - w0), 32'd1);
        rd(2, v); check("R12 count one element", v, 32'd28);
        rd(0, v); check("R12 src advanced", v, 32'h14);
        rd(8, v); check("R12 disarmed, no flag", v & 32'h3, 32'h0);
        check_copy(16'h10, 16'h90, 4, "R12 word written");
    endtask

    task automatic t_kill();
        logic [31:0] v;
        int w0;
        init_mem(); w0 = wcount;
        stall = 1'b1;
        setup(32'h30, 32'hB0, 32'd32, mk(2, 0, 1, 1, 2, 0, 0));
        wr(7, 32'h21);
        repeat (5) @(negedge clk);
        check("R13 read pending", 32'(bus_req), 32'd1);
        wr(7, 32'h10);
        check("R13 bus dropped", 32'(bus_req), 32'd0);
        stall = 1'b0;
        repeat (20) @(negedge clk);
        check("R13 nothing written", 32'(wcount - w0), 32'd0);
        rd(2, v); check("R13 count unchanged", v, 32'd32);
        rd(0, v); check("R13 src unchanged", v, 32'h30);
        rd(8, v); check("R13 disarmed, no flag", v & 32'h3, 32'h0);
        check("R13 irq low", 32'(irq), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_nonstop();
        t_single();
        t_decfixed();
        t_cont();
        t_reload();
        t_suspend();
        t_stop();
        t_kill();
        check("R4 gap kept overall", 32'(gap_err), 32'd0);
        finish_run();
    end
endmodule